// File: doc/BRIEF.md
# Configurable approximate 8x8 multiplier

This block multiplies two unsigned 8-bit operands with no clock. It splits each operand into four 2-bit fields and forms all sixteen field-by-field products in small 2x2 multiplier elements. Exact adders then combine the products, with each product weighted by its position. Each of the sixteen element positions is fixed at elaboration time to one of five element kinds: one exact kind and four approximate kinds, each with a fixed error pattern.

The approximate kinds are meant to be mixed. Kinds that err downward and kinds that err upward can be placed so that their errors cancel on average when the products are summed downstream. An upward-erring element can push a partial sum, or the whole product, past its nominal width. For that reason the intermediate 4x4 sums are 9 bits wide and the product is 17 bits wide.

Top module: `amul_mul8`

## Requirements
- R1: Operand field i (i = 0 is bits 1:0, up to i = 3 for bits 7:6) of A and field j of B feed element position p = 4*i + j. That element's 4-bit result is weighted by 4^(i+j). The kind code of position p is bits [3p+2:3p] of the parameter `ELEM_SEL`.
- R2: Kind code 0 (exact) gives the true product for all sixteen field pairs. Unused codes 5 to 7 behave as code 0.
- R3: Kind code 1 gives 0 for 1x1 and 2 for both 1x3 and 3x1. It is exact for every other pair.
- R4: Kind code 2 gives 7 for 3x3 and is exact elsewhere.
- R5: Kind code 3 gives 11 for 3x3 and is exact elsewhere.
- R6: Kind code 4 gives 5 for 3x3 and is exact elsewhere.
- R7: The 17-bit product never wraps. With every position set to code 3, 255 x 255 gives 79475.
- R8: If either operand is zero, the product is zero for every configuration.
- R9: With every position at code 0, the product equals A*B for all 65536 operand pairs.
- R10: If no position uses code 3, the product never exceeds A*B. If every position uses code 3, the product is never below A*B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 17 | Approximate product |

## Verification
The block is purely combinational, so every result is due in the same cycle its operands are applied. The bench changes the operands just after a rising clock edge and reads the product at the following falling edge, half a period later. At that point every path has settled, and the next operand change is still half a period away. Each operand pair therefore gets one clean sample, and its expected value comes from a per-field arithmetic model of the requirements.

// File: rtl/amul_pkg.sv
package amul_pkg;
  localparam int FIELD_W = 2;
  localparam int NFIELD  = 4;
  localparam int OP_W    = FIELD_W * NFIELD;
  localparam int NPOS    = NFIELD * NFIELD;
  localparam int KIND_W  = 3;
  localparam int ELEM_W  = 2 * FIELD_W;
  // largest element result is 11; a 4x4 group weights it by 16+4+4+1
  localparam int QUAD_W  = 9;
  localparam int PROD_W  = 17;

  typedef enum logic [KIND_W-1:0] {
    KIND_EXACT   = 3'd0,
    KIND_LOWTRIM = 3'd1,
    KIND_NEG2    = 3'd2,
    KIND_POS2    = 3'd3,
    KIND_NEG4    = 3'd4
  } elem_kind_e;

  function automatic int pos_of(input int fa, input int fb);
    return NFIELD * fa + fb;
  endfunction

  function automatic logic cfg_has(input logic [NPOS*KIND_W-1:0] cfg,
                                   input logic [KIND_W-1:0] kind);
    logic hit;
    hit = 1'b0;
    for (int p = 0; p < NPOS; p++)
      if (cfg[KIND_W*p +: KIND_W] == kind) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic cfg_all(input logic [NPOS*KIND_W-1:0] cfg,
                                   input logic [KIND_W-1:0] kind);
    logic all_hit;
    all_hit = 1'b1;
    for (int p = 0; p < NPOS; p++)
      if (cfg[KIND_W*p +: KIND_W] != kind) all_hit = 1'b0;
    return all_hit;
  endfunction
endpackage

// File: rtl/amul_elem.sv
module amul_elem
  import amul_pkg::*;
#(
  parameter logic [KIND_W-1:0] KIND = KIND_EXACT
) (
  input  logic [FIELD_W-1:0] a,
  input  logic [FIELD_W-1:0] b,
  output logic [ELEM_W-1:0]  p
);
  logic t00, t01, t10, t11;
  assign t00 = a[0] & b[0];
  assign t01 = a[0] & b[1];
  assign t10 = a[1] & b[0];
  assign t11 = a[1] & b[1];

  generate
    if (KIND == KIND_LOWTRIM) begin : g_lowtrim
      assign p = {t11 & t00, t11 & ~t00, t10 ^ t01, t11 & t00};
    end else if (KIND == KIND_NEG2) begin : g_neg2
      assign p = {1'b0, t11, t10 | t01, t00};
    end else if (KIND == KIND_POS2) begin : g_pos2
      assign p = {t11 & t00, t11 & ~t00, t10 | t01, t00};
    end else if (KIND == KIND_NEG4) begin : g_neg4
      assign p = {1'b0, t11, t10 ^ t01, t00};
    end else begin : g_exact
      assign p = {t11 & t00, t11 & ~t00, t10 ^ t01, t00};
    end
  endgenerate
endmodule

// File: rtl/amul_quad.sv
module amul_quad
  import amul_pkg::*;
#(
  parameter logic [NPOS*KIND_W-1:0] ELEM_SEL = '0,
  parameter int QA = 0,
  parameter int QB = 0
) (
  input  logic [2*FIELD_W-1:0] a,
  input  logic [2*FIELD_W-1:0] b,
  output logic [QUAD_W-1:0]    sum
);
  logic [ELEM_W-1:0] part [2][2];

  for (genvar ja = 0; ja < 2; ja++) begin : g_a
    for (genvar jb = 0; jb < 2; jb++) begin : g_b
      localparam int POS = pos_of(2*QA + ja, 2*QB + jb);
      amul_elem #(.KIND(ELEM_SEL[KIND_W*POS +: KIND_W])) u_elem (
        .a(a[FIELD_W*ja +: FIELD_W]),
        .b(b[FIELD_W*jb +: FIELD_W]),
        .p(part[ja][jb])
      );
    end
  end

  always_comb begin
    sum = '0;
    for (int ja = 0; ja < 2; ja++)
      for (int jb = 0; jb < 2; jb++)
        sum = sum + (QUAD_W'(part[ja][jb]) << (FIELD_W*(ja+jb)));
  end
endmodule

// File: rtl/amul_mul8.sv
module amul_mul8
  import amul_pkg::*;
#(
  parameter logic [NPOS*KIND_W-1:0] ELEM_SEL = {
    3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd0, 3'd0,
    3'd0, 3'd0, 3'd3, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1}
) (
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_b,
  output logic [16:0] product
);
  logic [QUAD_W-1:0] quad_sum [2][2];

  for (genvar qa = 0; qa < 2; qa++) begin : g_qa
    for (genvar qb = 0; qb < 2; qb++) begin : g_qb
      amul_quad #(.ELEM_SEL(ELEM_SEL), .QA(qa), .QB(qb)) u_quad (
        .a(op_a[4*qa +: 4]),
        .b(op_b[4*qb +: 4]),
        .sum(quad_sum[qa][qb])
      );
    end
  end

  always_comb begin
    product = '0;
    for (int qa = 0; qa < 2; qa++)
      for (int qb = 0; qb < 2; qb++)
        product = product + (PROD_W'(quad_sum[qa][qb]) << (4*(qa+qb)));
  end
endmodule

// File: rtl/amul_mul8_chk.sv
module amul_mul8_chk
  import amul_pkg::*;
#(
  parameter logic [NPOS*KIND_W-1:0] ELEM_SEL = '0
) (
  input logic [7:0]        op_a,
  input logic [7:0]        op_b,
  input logic [16:0]       product,
  input logic [QUAD_W-1:0] q00,
  input logic [QUAD_W-1:0] q01,
  input logic [QUAD_W-1:0] q10,
  input logic [QUAD_W-1:0] q11
);
  localparam logic HAS_POS = cfg_has(ELEM_SEL, KIND_POS2);
  localparam logic ALL_POS = cfg_all(ELEM_SEL, KIND_POS2);
  localparam logic ALL_EXT = cfg_all(ELEM_SEL, KIND_EXACT);

  logic [16:0] true_prod;
  assign true_prod = 17'(op_a) * 17'(op_b);

  always_comb begin
    // R8
    zero_operand_chk: assert (!(op_a == 8'd0 || op_b == 8'd0) || product == 17'd0);
    // R7
    quad_range_chk: assert (q00 <= 9'd275 && q01 <= 9'd275 && q10 <= 9'd275 && q11 <= 9'd275);
    // R10
    no_overflow_chk: assert (HAS_POS || product[16] == 1'b0);
    // R10
    below_exact_chk: assert (HAS_POS || product <= true_prod);
    // R10
    above_exact_chk: assert (!ALL_POS || product >= true_prod);
    // R9
    exact_cfg_chk: assert (!ALL_EXT || product == true_prod);
  end
endmodule

bind amul_mul8 amul_mul8_chk #(.ELEM_SEL(ELEM_SEL)) u_chk (
  .op_a(op_a), .op_b(op_b), .product(product),
  .q00(quad_sum[0][0]), .q01(quad_sum[0][1]),
  .q10(quad_sum[1][0]), .q11(quad_sum[1][1])
);

// File: tb/sim_amul_mul8.sv
module sim_amul_mul8;
  localparam logic [47:0] CFG_MIX = {
    3'd2, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd0, 3'd0,
    3'd0, 3'd0, 3'd3, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1};
  localparam logic [47:0] CFG_POS = {16{3'd3}};
  localparam logic [47:0] CFG_EXT = {16{3'd7}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] a = 8'd0, b = 8'd0;
  logic [16:0] p_mix, p_pos, p_ext;
  int n_run = 0, n_fail = 0;
  int cycles = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  amul_mul8 #(.ELEM_SEL(CFG_MIX)) u0 (.op_a(a), .op_b(b), .product(p_mix));
  amul_mul8 #(.ELEM_SEL(CFG_POS)) u1 (.op_a(a), .op_b(b), .product(p_pos));
  amul_mul8 #(.ELEM_SEL(CFG_EXT)) u2 (.op_a(a), .op_b(b), .product(p_ext));

  function automatic int elem_ref(input int kind, input int x, input int y);
    int e;
    e = x * y;
    case (kind)
      1: if ((x == 1 && y == 1) || (x * y == 3)) e = e - 1;
      2: if (x == 3 && y == 3) e = e - 2;
      3: if (x == 3 && y == 3) e = e + 2;
      4: if (x == 3 && y == 3) e = e - 4;
      default: ;
    endcase
    return e;
  endfunction

  function automatic int model(input logic [47:0] cfg, input int x, input int y);
    int acc;
    acc = 0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        acc += elem_ref(int'(cfg[3*(4*i+j) +: 3]), (x >> (2*i)) & 3, (y >> (2*j)) & 3)
               * (1 << (2*(i+j)));
    return acc;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d got=%0d exp=%0d", req, a, b, got, exp);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(posedge clk);
    a = 8'(x);
    b = 8'(y);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(0, 0);
    // R8 reset-state operands
    check("R8", int'(p_mix), 0);
    check("R8", int'(p_pos), 0);
    // R3: position 0 holds kind 1
    apply(1, 1);  check("R3", int'(p_mix), 0);
    apply(1, 3);  check("R3", int'(p_mix), 2);
    apply(3, 1);  check("R3", int'(p_mix), 2);
    apply(3, 3);  check("R3", int'(p_mix), 9);
    // R1 R4: position 15 kind 2, weight 4096
    apply(8'hC0, 8'hC0); check("R4", int'(p_mix), 28672);
    // R1 R5: position 5 kind 3, weight 16
    apply(8'h0C, 8'h0C); check("R5", int'(p_mix), 176);
    // R1 R6: position 3 (A field 0, B field 3) kind 4, weight 64
    apply(8'h03, 8'hC0); check("R6", int'(p_mix), 320);
    // R2 R9: codes 7 act as exact
    apply(8'hC0, 8'hC0); check("R2", int'(p_ext), 36864);
    // R7: all-upward config at the corner
    apply(255, 255); check("R7", int'(p_pos), 79475);
    check("R9", int'(p_ext), 65025);
    // full sweep, R1 R8 R9 R10
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        apply(x, y);
        check("R1", int'(p_mix), model(CFG_MIX, x, y));
        check("R7", int'(p_pos), model(CFG_POS, x, y));
        check("R9", int'(p_ext), x * y);
        if (int'(p_pos) < x * y) check("R10", int'(p_pos), x * y);
        if (x == 0 || y == 0) check("R8", int'(p_mix), 0);
      end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule